// File: doc/BRIEF.md
# Masked Vector Compress and Expand Unit

This block moves elements of one vector register between positions under the control of a per-element mask. In compress mode it gathers the elements whose mask bit is set and lays them down side by side from element 0 of the result, in their original order, and reports how many it placed. In expand mode it works the other way round. It takes source elements 0, 1, 2 and so on in order and drops each one into the next result position whose mask bit is set.

A client presents the source vector, the previous destination contents, the mask and a mode, then pulses `start`. The unit captures all operands on that edge. It then scans one element index per clock and raises `done` for a single cycle when the scan is over. Positions that the operation does not write keep the previous destination contents. The result and the count stay unchanged after `done` until the next start is accepted.

Top module: `vpk_unit`

## Requirements
- R1: After reset, `done` is 0, `count` is 0 and `res_vec` is all zeros.
- R2: With `mode`=0 (compress), result element k, for k below the packed length, equals the k-th source element whose mask bit is 1, counted from element 0 upward. Element i occupies bits [i*EW +: EW] of every vector port, and mask bit i belongs to element i.
- R3: With `mode`=0, result elements at or above the packed length equal the corresponding elements of `old_vec` captured at start.
- R4: When `done` is high, `count` equals the number of 1 bits in the captured mask, in both modes.
- R5: With `mode`=1 (expand), the result element at the j-th set mask position (j counted from 0, lowest position first) equals source element j.
- R6: With `mode`=1, result elements whose mask bit is 0 equal the corresponding elements of `old_vec`.
- R7: A start that is accepted on a rising edge leads to `done` being high for exactly one cycle, beginning after the VLEN-th rising edge that follows the accepting edge. Capture plus scan take VLEN+1 edges.
- R8: A `start` pulse while an operation is in progress is ignored. The running operation completes with its own operands, mode and timing.
- R9: With an all-zero mask, `count` is 0 and `res_vec` equals `old_vec`, in either mode.
- R10: Once idle, `res_vec` and `count` keep their values, whatever the inputs do, until a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when the unit is idle |
| mode | input | 1 | 0 = compress, 1 = expand |
| src_vec | input | VLEN*EW | Source vector |
| old_vec | input | VLEN*EW | Previous destination contents |
| mask | input | VLEN | One bit per element |
| res_vec | output | VLEN*EW | Result vector |
| count | output | $clog2(VLEN+1) | Number of elements moved |
| done | output | 1 | One-cycle completion pulse |

## Verification
Compress and expand are each run with these masks:
- An alternating pattern, which separates order-preserving packing from a plain copy.
- A single low bit and a single high bit, which expose pointer offsets at both ends.
- A full mask, which shows a full-length move with no old contents left.
- An irregular mask, which catches pointer slips in the middle of a scan.

The all-zero mask confirms that nothing is written and that the count reads zero. A second start issued mid-scan with different data checks that the first operation's results are unaffected. Changing the inputs after completion without a start checks that the result and count hold.

// File: rtl/vpk_pkg.sv
package vpk_pkg;
   typedef enum logic {
      VPK_COMPRESS = 1'b0,
      VPK_EXPAND   = 1'b1
   } vpk_mode_e;

   typedef enum logic {
      VPK_IDLE = 1'b0,
      VPK_RUN  = 1'b1
   } vpk_state_e;
endpackage

// File: rtl/vpk_ctrl.sv
module vpk_ctrl
   import vpk_pkg::*;
#(
   parameter int VLEN = 8,
   parameter int IW   = (VLEN > 1) ? $clog2(VLEN) : 1,
   parameter int PW   = $clog2(VLEN + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            mode_in,
   input  logic [VLEN-1:0] mask_in,
   output logic            load,
   output logic            step,
   output logic            busy,
   output vpk_mode_e       mode_q,
   output logic [IW-1:0]   idx,
   output logic [PW-1:0]   ptr,
   output logic            done
);
   localparam logic [IW-1:0] LAST_IDX = IW'(VLEN - 1);

   vpk_state_e      state_q;
   logic [VLEN-1:0] mask_q;

   initial begin
      assert (VLEN >= 2) else $error("vpk_ctrl: VLEN must be at least 2");
      assert (PW > 0 && IW > 0) else $error("vpk_ctrl: bad derived widths");
   end

   assign busy = (state_q == VPK_RUN);
   assign load = start && !busy;
   assign step = busy && mask_q[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= VPK_IDLE;
         mask_q  <= '0;
         mode_q  <= VPK_COMPRESS;
         idx     <= '0;
         ptr     <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            state_q <= VPK_RUN;
            mask_q  <= mask_in;
            mode_q  <= vpk_mode_e'(mode_in);
            idx     <= '0;
            ptr     <= '0;
         end else if (busy) begin
            if (mask_q[idx]) ptr <= ptr + PW'(1);
            if (idx == LAST_IDX) begin
               state_q <= VPK_IDLE;
               done    <= 1'b1;
            end else begin
               idx <= idx + IW'(1);
            end
         end
      end
   end

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   count_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(ptr) == $countones(mask_q)));

   // R8
   run_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx != LAST_IDX) |=> (busy && idx == $past(idx) + IW'(1)
                                     && $stable(mask_q) && $stable(mode_q)));

   // R2
   ptr_behind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (int'(ptr) <= int'(idx)));
endmodule

// File: rtl/vpk_regs.sv
module vpk_regs
   import vpk_pkg::*;
#(
   parameter int VLEN = 8,
   parameter int EW   = 16,
   parameter int IW   = (VLEN > 1) ? $clog2(VLEN) : 1,
   parameter int VW   = VLEN * EW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            step,
   input  vpk_mode_e       mode_q,
   input  logic [IW-1:0]   idx,
   input  logic [IW-1:0]   ptr_lo,
   input  logic [VW-1:0]   src_in,
   input  logic [VW-1:0]   old_in,
   output logic [VW-1:0]   res
);
   logic [VW-1:0] src_q;
   logic [EW-1:0] src_el [VLEN];
   logic [IW-1:0] rd_sel;
   logic [IW-1:0] wr_sel;
   logic [EW-1:0] rd_el;

   initial begin
      assert (EW >= 1) else $error("vpk_regs: EW must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    src_q <= '0;
      else if (load) src_q <= src_in;
   end

   // compress reads at the scan index and writes at the pack pointer;
   // expand swaps the two roles
   assign rd_sel = (mode_q == VPK_EXPAND) ? ptr_lo : idx;
   assign wr_sel = (mode_q == VPK_EXPAND) ? idx : ptr_lo;
   assign rd_el  = src_el[rd_sel];

   for (genvar g = 0; g < VLEN; g++) begin : g_slot
      logic [EW-1:0] slot_q;

      assign src_el[g]       = src_q[g*EW +: EW];
      assign res[g*EW +: EW] = slot_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (load)
            slot_q <= old_in[g*EW +: EW];
         else if (step && wr_sel == IW'(g))
            slot_q <= rd_el;
      end
   end
endmodule

// File: rtl/vpk_unit.sv
module vpk_unit
   import vpk_pkg::*;
#(
   parameter int VLEN = 8,
   parameter int EW   = 16,
   localparam int IW  = (VLEN > 1) ? $clog2(VLEN) : 1,
   localparam int PW  = $clog2(VLEN + 1),
   localparam int VW  = VLEN * EW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            mode,
   input  logic [VW-1:0]   src_vec,
   input  logic [VW-1:0]   old_vec,
   input  logic [VLEN-1:0] mask,
   output logic [VW-1:0]   res_vec,
   output logic [PW-1:0]   count,
   output logic            done
);
   logic          load;
   logic          step;
   logic          busy;
   vpk_mode_e     mode_q;
   logic [IW-1:0] idx;
   logic [PW-1:0] ptr;

   vpk_ctrl #(.VLEN(VLEN), .IW(IW), .PW(PW)) i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .mode_in (mode),
      .mask_in (mask),
      .load    (load),
      .step    (step),
      .busy    (busy),
      .mode_q  (mode_q),
      .idx     (idx),
      .ptr     (ptr),
      .done    (done)
   );

   vpk_regs #(.VLEN(VLEN), .EW(EW), .IW(IW), .VW(VW)) i_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .step   (step),
      .mode_q (mode_q),
      .idx    (idx),
      .ptr_lo (ptr[IW-1:0]),
      .src_in (src_vec),
      .old_in (old_vec),
      .res    (res_vec)
   );

   assign count = ptr;

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(res_vec) && $stable(count)));

   // R7
   done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !busy);
endmodule

// File: tb/test_vpk_unit.sv
module test_vpk_unit;
   localparam int VLEN = 8;
   localparam int EW   = 16;
   localparam int VW   = VLEN * EW;
   localparam int PW   = $clog2(VLEN + 1);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic            mode = 1'b0;
   logic [VW-1:0]   src_vec = '0;
   logic [VW-1:0]   old_vec = '0;
   logic [VLEN-1:0] mask = '0;
   logic [VW-1:0]   res_vec;
   logic [PW-1:0]   count;
   logic            done;

   int n_checks = 0;
   int n_errors = 0;

   always #5 clk = ~clk;

   vpk_unit #(.VLEN(VLEN), .EW(EW)) i_vpk_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .src_vec(src_vec), .old_vec(old_vec), .mask(mask),
      .res_vec(res_vec), .count(count), .done(done)
   );

   task automatic check(input bit ok, input string req,
                        input logic [VW-1:0] act, input logic [VW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [VW-1:0] model_vec(input bit m, input logic [VW-1:0] s,
                                              input logic [VW-1:0] o,
                                              input logic [VLEN-1:0] mk);
      logic [VW-1:0] r = o;
      int p = 0;
      for (int i = 0; i < VLEN; i++) begin
         if (mk[i]) begin
            if (!m) r[p*EW +: EW] = s[i*EW +: EW];
            else    r[i*EW +: EW] = s[p*EW +: EW];
            p++;
         end
      end
      return r;
   endfunction

   function automatic int pop(input logic [VLEN-1:0] mk);
      int c = 0;
      for (int i = 0; i < VLEN; i++) c += int'(mk[i]);
      return c;
   endfunction

   function automatic logic [VW-1:0] make_src(input int seed);
      logic [VW-1:0] v;
      for (int i = 0; i < VLEN; i++) v[i*EW +: EW] = EW'(16'h1000 * seed + 16'h0011 * (i + 1));
      return v;
   endfunction

   // Checks element groups separately so each requirement is named
   task automatic check_result(input bit m, input logic [VW-1:0] s,
                               input logic [VW-1:0] o, input logic [VLEN-1:0] mk,
                               input string tag);
      logic [VW-1:0] exp = model_vec(m, s, o, mk);
      bit ok_main = 1'b1;
      bit ok_keep = 1'b1;
      int cnt = pop(mk);
      for (int i = 0; i < VLEN; i++) begin
         bit written = m ? mk[i] : (i < cnt);
         if (res_vec[i*EW +: EW] !== exp[i*EW +: EW]) begin
            if (written) ok_main = 1'b0;
            else         ok_keep = 1'b0;
         end
      end
      if (!m) begin
         check(ok_main, {"R2 packed elements ", tag}, res_vec, exp);
         check(ok_keep, {"R3 slots above count ", tag}, res_vec, exp);
      end else begin
         check(ok_main, {"R5 set positions ", tag}, res_vec, exp);
         check(ok_keep, {"R6 clear positions ", tag}, res_vec, exp);
      end
      check(int'(count) == cnt, {"R4 count ", tag}, VW'(count), VW'(cnt));
   endtask

   // Runs one operation; optionally fires a second start mid-scan (R8)
   task automatic run_op(input bit m, input logic [VW-1:0] s, input logic [VW-1:0] o,
                         input logic [VLEN-1:0] mk, input bit poke, input string tag);
      bit early = 1'b0;
      @(negedge clk);
      mode = m; src_vec = s; old_vec = o; mask = mk; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 1; k <= VLEN; k++) begin
         if (done) early = 1'b1;
         if (poke && k == 3) begin
            mode = ~m; src_vec = ~s; old_vec = ~o; mask = ~mk; start = 1'b1;
         end
         @(negedge clk);
         start = 1'b0;
      end
      check(!early && done, {"R7 done timing ", tag}, VW'(done), VW'(1));
      check_result(m, s, o, mk, tag);
      @(negedge clk);
      check(!done, {"R7 done single cycle ", tag}, VW'(done), VW'(0));
   endtask

   task automatic test_reset();
      check(!done, "R1 done after reset", VW'(done), VW'(0));
      check(count == '0, "R1 count after reset", VW'(count), VW'(0));
      check(res_vec == '0, "R1 result after reset", res_vec, '0);
   endtask

   task automatic test_compress();
      run_op(1'b0, make_src(1), make_src(9), 8'b1010_1010, 1'b0, "cmp alt");
      run_op(1'b0, make_src(2), make_src(9), 8'b0000_0001, 1'b0, "cmp low");
      run_op(1'b0, make_src(3), make_src(9), 8'b1000_0000, 1'b0, "cmp high");
      run_op(1'b0, make_src(4), make_src(9), 8'b1111_1111, 1'b0, "cmp full");
      run_op(1'b0, make_src(5), make_src(9), 8'b0110_1001, 1'b0, "cmp mixed");
   endtask

   task automatic test_expand();
      run_op(1'b1, make_src(1), make_src(8), 8'b1010_1010, 1'b0, "exp alt");
      run_op(1'b1, make_src(2), make_src(8), 8'b0000_0001, 1'b0, "exp low");
      run_op(1'b1, make_src(3), make_src(8), 8'b1000_0000, 1'b0, "exp high");
      run_op(1'b1, make_src(4), make_src(8), 8'b1111_1111, 1'b0, "exp full");
      run_op(1'b1, make_src(5), make_src(8), 8'b0110_1001, 1'b0, "exp mixed");
   endtask

   task automatic test_zero_mask();
      run_op(1'b0, make_src(6), make_src(7), '0, 1'b0, "R9 cmp zero");
      check(res_vec == make_src(7) && count == '0, "R9 compress zero mask",
            res_vec, make_src(7));
      run_op(1'b1, make_src(6), make_src(5), '0, 1'b0, "R9 exp zero");
      check(res_vec == make_src(5) && count == '0, "R9 expand zero mask",
            res_vec, make_src(5));
   endtask

   task automatic test_busy_start();
      run_op(1'b0, make_src(3), make_src(4), 8'b0011_0100, 1'b1, "R8 cmp busy start");
      run_op(1'b1, make_src(2), make_src(6), 8'b1100_0010, 1'b1, "R8 exp busy start");
   endtask

   task automatic test_hold();
      logic [VW-1:0] exp_v;
      logic [PW-1:0] exp_c;
      run_op(1'b0, make_src(1), make_src(2), 8'b0101_0011, 1'b0, "R10 setup");
      exp_v = res_vec;
      exp_c = count;
      @(negedge clk);
      mode = 1'b1; src_vec = ~src_vec; old_vec = ~old_vec; mask = 8'hFF;
      repeat (4) @(negedge clk);
      check(res_vec == exp_v, "R10 result holds while idle", res_vec, exp_v);
      check(count == exp_c, "R10 count holds while idle", VW'(count), VW'(exp_c));
      check(!done, "R10 no done while idle", VW'(done), VW'(0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_compress();
      test_expand();
      test_zero_mask();
      test_busy_start();
      test_hold();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule